// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order address bits for each beat of a short burst on a synchronous memory port. A load cycle captures the low bits of the external address as the start point and resets the beat index. Each advance cycle moves one beat on. The address for the current beat is formed from the start point and the beat index in one of two orders, chosen by a strap input:

- **Interleaved order:** the start point XORed with the beat index.
- **Linear order:** the start point plus the beat index, modulo the burst length.

The upper address bits are routed around the block and are not handled here.

A stall input freezes all state, so the block follows a port whose clock can be suspended. Load takes priority over advance. After the last beat, an advance wraps back to the start point instead of stopping.

The order strap is meant to be tied off. It may only change while reset is held. All pins are plain control and status pins with no flow control, because one beat address is valid in every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `burst_lsb` and `beat_idx` are both zero.
- R2: A clock edge with `stall` low and `load` high captures `ext_lsb` as the start point and sets `beat_idx` to 0, whatever `advance` is. From the next cycle, `burst_lsb` equals the captured bits.
- R3: A clock edge with `stall` low, `load` low and `advance` high raises `beat_idx` by one, modulo 2^LSB_W.
- R4: With `seq_interleave` = 1, `burst_lsb` equals the start point XOR `beat_idx`. For 2 bits and start 01, the beats are 01, 00, 11, 10.
- R5: With `seq_interleave` = 0, `burst_lsb` equals the start point plus `beat_idx`, modulo 2^LSB_W. For start 10, the beats are 10, 11, 00, 01.
- R6: A clock edge with `stall` high leaves `burst_lsb` and `beat_idx` unchanged, whatever `load`, `advance` and `ext_lsb` are.
- R7: A clock edge with `stall`, `load` and `advance` all low leaves `burst_lsb` and `beat_idx` unchanged.
- R8: An advance taken on the last beat (`beat_idx` all ones) returns `beat_idx` to 0 and `burst_lsb` to the start point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | High suspends the block; all state holds |
| load | input | 1 | Capture `ext_lsb` as a new burst start |
| advance | input | 1 | Step to the next beat |
| ext_lsb | input | LSB_W | Low bits of the external address |
| seq_interleave | input | 1 | Order strap: 1 interleaved, 0 linear; static outside reset |
| burst_lsb | output | LSB_W | Low address bits of the current beat |
| beat_idx | output | LSB_W | Index of the current beat within the burst |

## Verification
The bench builds the block with its default 2-bit width, which is the four-beat burst. At this width every start point can be tried in both orders, and the full sequence plus the wrap can be walked out in five advances. Random runs mix stalls, idle cycles, and collisions of load with advance over all start points. The order strap is changed only under reset, and the bench covers both of its values.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_SEED = 2'd2
  } burst_op_e;
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
#(
  parameter int LSB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             load,
  input  logic             advance,
  input  logic [LSB_W-1:0] ext_lsb,
  output logic [LSB_W-1:0] start_q,
  output logic [LSB_W-1:0] beat_q
);
  localparam logic [LSB_W-1:0] ONE = LSB_W'(1);

  burst_op_e op;

  always_comb begin
    if (stall)        op = OP_HOLD;
    else if (load)    op = OP_SEED;
    else if (advance) op = OP_STEP;
    else              op = OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      case (op)
        OP_SEED: begin
          start_q <= ext_lsb;
          beat_q  <= '0;
        end
        OP_STEP: beat_q <= beat_q + ONE;
        default: ;
      endcase
    end
  end

  // R6
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(start_q) && $stable(beat_q)));

  // R2
  a_r2_load_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load) |=> (beat_q == '0 && start_q == $past(ext_lsb)));

  // R3
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load && advance) |=>
      (beat_q == LSB_W'($past(beat_q) + ONE) && $stable(start_q)));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load && !advance) |=> ($stable(start_q) && $stable(beat_q)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int LSB_W = 2
) (
  input  logic             order_sel,
  input  logic [LSB_W-1:0] start_lsb,
  input  logic [LSB_W-1:0] beat,
  output logic [LSB_W-1:0] addr_lsb
);
  logic [LSB_W-1:0] xor_path;
  logic [LSB_W-1:0] sum_path;
  logic [LSB_W:0]   carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < LSB_W; i++) begin : g_bit
    assign xor_path[i]  = start_lsb[i] ^ beat[i];
    assign sum_path[i]  = xor_path[i] ^ carry[i];
    assign carry[i+1]   = (start_lsb[i] & beat[i]) | (carry[i] & xor_path[i]);
  end

  logic unused_carry;
  assign unused_carry = carry[LSB_W];

  always_comb begin
    if (burst_order_e'(order_sel) == ORD_INTERLEAVE) addr_lsb = xor_path;
    else                                             addr_lsb = sum_path;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int LSB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             load,
  input  logic             advance,
  input  logic [LSB_W-1:0] ext_lsb,
  input  logic             seq_interleave,
  output logic [LSB_W-1:0] burst_lsb,
  output logic [LSB_W-1:0] beat_idx
);
  localparam logic [LSB_W-1:0] LAST_BEAT = {LSB_W{1'b1}};

  logic [LSB_W-1:0] start_q;
  logic [LSB_W-1:0] beat_q;

  burst_beat_counter #(.LSB_W(LSB_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .load    (load),
    .advance (advance),
    .ext_lsb (ext_lsb),
    .start_q (start_q),
    .beat_q  (beat_q)
  );

  burst_order_map #(.LSB_W(LSB_W)) u_map (
    .order_sel (seq_interleave),
    .start_lsb (start_q),
    .beat      (beat_q),
    .addr_lsb  (burst_lsb)
  );

  assign beat_idx = beat_q;

  // R8
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load && advance && beat_idx == LAST_BEAT) |=>
      (beat_idx == '0 && burst_lsb == start_q));

  // R4
  a_r4_interleave_beat1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_interleave && beat_idx == LSB_W'(1)) |->
      (burst_lsb == {start_q[LSB_W-1:1], ~start_q[0]}));

  // R5
  a_r5_linear_beat1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_interleave && beat_idx == LSB_W'(1)) |->
      (burst_lsb == LSB_W'(start_q + LSB_W'(1))));

  // R2: the start point is addressed on beat 0 in both orders
  a_r2_beat0_start: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_idx == '0) |-> (burst_lsb == start_q));

  a_strap_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(seq_interleave));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int W = 2;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stall = 1'b0, load = 1'b0, advance = 1'b0;
  logic [W-1:0] ext_lsb = '0;
  logic         seq_interleave = 1'b1;
  logic [W-1:0] burst_lsb, beat_idx;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_start = '0, m_beat = '0;

  always #2 clk = ~clk;

  burst_addr_gen #(.LSB_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .load(load), .advance(advance),
    .ext_lsb(ext_lsb), .seq_interleave(seq_interleave),
    .burst_lsb(burst_lsb), .beat_idx(beat_idx)
  );

  function automatic logic [W-1:0] exp_addr(logic mode, logic [W-1:0] s, logic [W-1:0] b);
    return mode ? (s ^ b) : W'(s + b);
  endfunction

  task automatic check(string req, logic [W-1:0] exp_a, logic [W-1:0] exp_b);
    checks++;
    if (burst_lsb !== exp_a || beat_idx !== exp_b) begin
      errors++;
      $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
               req, burst_lsb, beat_idx, exp_a, exp_b);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; stall = 0; load = 0; advance = 0;
    seq_interleave = mode;
    repeat (2) @(negedge clk);
    check("R1", '0, '0);
    rst_n = 1'b1;
    m_start = '0; m_beat = '0;
    @(negedge clk);
    check("R1", '0, '0);
  endtask

  task automatic cyc(logic st, logic ld, logic adv, logic [W-1:0] ext);
    string req;
    stall = st; load = ld; advance = adv; ext_lsb = ext;
    @(negedge clk);
    if (st) req = "R6";
    else if (ld) req = "R2";
    else if (adv) req = (m_beat == W'(N-1)) ? "R8" : "R3";
    else req = "R7";
    if (!st) begin
      if (ld) begin m_start = ext; m_beat = '0; end
      else if (adv) m_beat = W'(m_beat + 1);
    end
    check(req, exp_addr(seq_interleave, m_start, m_beat), m_beat);
    if (!st && !ld) check(seq_interleave ? "R4" : "R5",
                          exp_addr(seq_interleave, m_start, m_beat), m_beat);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int m = 1; m >= 0; m--) begin
      do_reset(m[0]);
      for (int s = 0; s < N; s++) begin
        cyc(0, 1, 0, W'(s));
        for (int k = 0; k < N + 1; k++) cyc(0, 0, 1, W'(~s));
      end
      cyc(0, 1, 0, W'(2));
      cyc(0, 0, 1, '0);
      cyc(0, 1, 1, W'(1));          // R2 load wins over advance
      cyc(1, 1, 0, W'(3));          // R6 stall blocks load
      cyc(1, 0, 1, W'(3));          // R6 stall blocks advance
      cyc(0, 0, 0, W'(3));          // R7 idle
      for (int i = 0; i < 400; i++) begin
        logic st, ld, adv;
        st  = ($urandom % 5) == 0;
        ld  = ($urandom % 4) == 0;
        adv = ($urandom % 3) != 0;
        cyc(st, ld, adv, W'($urandom));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule